// File: doc/BRIEF.md
# Floating-Point Operate Instruction Decoder

This block takes a 32-bit floating-point operate instruction and works out what it asks for, without carrying out the arithmetic. It sorts the word into one of two operate groups: general operations, or compares that write a condition code. It pulls out the 9-bit operation code and the three 5-bit register fields. From the operation code it gives each register field an operand size: unused, single, double, quad, a raw 32-bit word, or the condition-code destination.

Each used register number is then checked against its size. Double operands need an even register, and quad operands need a register that is a multiple of four. A compare must name destination zero. When any of these checks fails, the block reports an illegal-register error with trap type 6, and it names the first operand that failed in the order rs1, rs2, rd. An instruction that lies outside both groups, or whose code is not defined in its group, is reported as unimplemented.

One strobe on the input gives one registered result a cycle later. An execution pipeline or a trap handler can read that result to route the operands or to raise the right exception.

Top module: `fpop_decoder`

## Requirements
- R1: While reset is asserted and after it is released, before any strobe, every output is zero.
- R2: `dec_valid` is high exactly one cycle after each cycle in which `in_valid` is high. All other outputs change only in the cycle after a strobe and hold otherwise.
- R3: The word is a general operate when `(insn & 0xC1F80000) == 0x81A00000` and a compare operate when the masked value is `0x81A80000`. Any other word is reported with `dec_unimp`=1.
- R4: `dec_opf` = insn[13:5], `dec_rs1` = insn[18:14], `dec_rs2` = insn[4:0] and `dec_rd` = insn[29:25]. These are reported for every strobed word, whether or not it decodes.
- R5: Size codes are 0 unused, 1 single, 2 double, 3 quad, 4 raw 32-bit word, 5 condition code. Some examples of (rs1, rs2, rd) sizes: add 0x041/0x042/0x043 give (1,1,1)/(2,2,2)/(3,3,3). Single-times-single-to-double 0x069 gives (1,1,2). Double-times-double-to-quad 0x06E gives (2,2,3). Conversions to integer 0x0D1/0x0D2/0x0D3 give (0,1/2/3,4). Integer-to-float 0x0C4/0x0C8/0x0CC give (0,4,1/2/3). Square root 0x029/0x02A/0x02B gives (0,n,n). Compares 0x051/0x055, 0x052/0x056 and 0x053/0x057 give (1,1,5), (2,2,5) and (3,3,5).
- R6: An operation code that is not defined for its group gives `dec_unimp`=1, all three sizes 0, `dec_reg_err`=0, trap type 0 and error source 0. This includes a compare code in the general group and a general code in the compare group.
- R7: A double-size operand with an odd register number is illegal.
- R8: A quad-size operand whose register number has bit 1 or bit 0 set is illegal.
- R9: A condition-code destination with a non-zero rd field is illegal.
- R10: `dec_trap_type` is 6 when `dec_reg_err` is 1, and 0 otherwise.
- R11: `dec_err_src` names the first failing operand in check order: 1 for rs1, 2 for rs2, 3 for rd. It is 0 when there is no error.
- R12: After each strobe, exactly one of `dec_ok`, `dec_unimp` and `dec_reg_err` is 1.
- R13: Operands of size unused, single or raw word are never illegal, whatever their register number. This covers single move 0x001, negate 0x005 and absolute value 0x009, which have sizes (0,4,4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Strobe: decode `insn` this cycle |
| insn | input | 32 | Instruction word |
| dec_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| dec_ok | output | 1 | Recognised operation with legal registers |
| dec_unimp | output | 1 | Not an operate group, or code undefined in its group |
| dec_reg_err | output | 1 | Illegal register number for the operand size |
| dec_trap_type | output | 3 | 6 on illegal register, else 0 |
| dec_err_src | output | 2 | First failing operand: 1 rs1, 2 rs2, 3 rd |
| dec_opf | output | 9 | Operation code field |
| dec_rs1_sz | output | 3 | rs1 size code |
| dec_rs2_sz | output | 3 | rs2 size code |
| dec_rd_sz | output | 3 | rd size code |
| dec_rs1 | output | 5 | rs1 register number |
| dec_rs2 | output | 5 | rs2 register number |
| dec_rd | output | 5 | rd register number |

## Verification
The hardest outcome to reach from the ports is an error source that depends on priority: two or three operands are misaligned at once, and the report must name rs1 ahead of rd, or rs2 ahead of rd. Uniformly random words almost never land in an operate group, let alone with a defined code and a bad register. The stimulus therefore builds words with the group bits forced and the code picked from the defined set. It mixes in register numbers biased toward odd values and values that are not multiples of four, and directed cases stack several faults in one compare or quad operation.

// File: rtl/fpdec_pkg.sv
// Package: shared constants and types for the floating-point operate decoder.
// Assumes the fixed 32-bit instruction layout; field positions are behaviour.
package fpdec_pkg;

    localparam int INSN_W = 32;
    localparam int REG_W  = 5;
    localparam int OPF_W  = 9;
    localparam int TT_W   = 3;
    localparam int SZ_W   = 3;
    localparam int NUM_OPERANDS = 3;
    localparam int SRC_W  = $clog2(NUM_OPERANDS + 1);

    // Field positions
    localparam int OPF_LO = 5;
    localparam int RS1_LO = 14;
    localparam int RS2_LO = 0;
    localparam int RD_LO  = 25;

    // Group match
    localparam logic [INSN_W-1:0] GRP_MASK  = 32'hC1F8_0000;
    localparam logic [INSN_W-1:0] GRP_ARITH = 32'h81A0_0000;
    localparam logic [INSN_W-1:0] GRP_CMP   = 32'h81A8_0000;

    localparam logic [TT_W-1:0] TT_NONE   = 3'd0;
    localparam logic [TT_W-1:0] TT_BADREG = 3'd6;

    typedef enum logic [SZ_W-1:0] {
        SZ_NONE = 3'd0,
        SZ_SGL  = 3'd1,
        SZ_DBL  = 3'd2,
        SZ_QUAD = 3'd3,
        SZ_WORD = 3'd4,
        SZ_FCC  = 3'd5
    } opsz_e;

    typedef struct packed {
        opsz_e a;   // rs1
        opsz_e b;   // rs2
        opsz_e d;   // rd
    } opsig_t;

    localparam opsig_t SIG_NONE = '{a: SZ_NONE, b: SZ_NONE, d: SZ_NONE};

    // Operation codes, general group
    localparam logic [OPF_W-1:0] OP_MOV_S  = 9'h001;
    localparam logic [OPF_W-1:0] OP_NEG_S  = 9'h005;
    localparam logic [OPF_W-1:0] OP_ABS_S  = 9'h009;
    localparam logic [OPF_W-1:0] OP_SQR_S  = 9'h029;
    localparam logic [OPF_W-1:0] OP_SQR_D  = 9'h02A;
    localparam logic [OPF_W-1:0] OP_SQR_Q  = 9'h02B;
    localparam logic [OPF_W-1:0] OP_ADD_S  = 9'h041;
    localparam logic [OPF_W-1:0] OP_ADD_D  = 9'h042;
    localparam logic [OPF_W-1:0] OP_ADD_Q  = 9'h043;
    localparam logic [OPF_W-1:0] OP_SUB_S  = 9'h045;
    localparam logic [OPF_W-1:0] OP_SUB_D  = 9'h046;
    localparam logic [OPF_W-1:0] OP_SUB_Q  = 9'h047;
    localparam logic [OPF_W-1:0] OP_MUL_S  = 9'h049;
    localparam logic [OPF_W-1:0] OP_MUL_D  = 9'h04A;
    localparam logic [OPF_W-1:0] OP_MUL_Q  = 9'h04B;
    localparam logic [OPF_W-1:0] OP_DIV_S  = 9'h04D;
    localparam logic [OPF_W-1:0] OP_DIV_D  = 9'h04E;
    localparam logic [OPF_W-1:0] OP_DIV_Q  = 9'h04F;
    localparam logic [OPF_W-1:0] OP_WMUL_D = 9'h069;
    localparam logic [OPF_W-1:0] OP_WMUL_Q = 9'h06E;
    localparam logic [OPF_W-1:0] OP_I2S    = 9'h0C4;
    localparam logic [OPF_W-1:0] OP_D2S    = 9'h0C6;
    localparam logic [OPF_W-1:0] OP_Q2S    = 9'h0C7;
    localparam logic [OPF_W-1:0] OP_I2D    = 9'h0C8;
    localparam logic [OPF_W-1:0] OP_S2D    = 9'h0C9;
    localparam logic [OPF_W-1:0] OP_Q2D    = 9'h0CB;
    localparam logic [OPF_W-1:0] OP_I2Q    = 9'h0CC;
    localparam logic [OPF_W-1:0] OP_S2Q    = 9'h0CD;
    localparam logic [OPF_W-1:0] OP_D2Q    = 9'h0CE;
    localparam logic [OPF_W-1:0] OP_S2I    = 9'h0D1;
    localparam logic [OPF_W-1:0] OP_D2I    = 9'h0D2;
    localparam logic [OPF_W-1:0] OP_Q2I    = 9'h0D3;
    // Compare group
    localparam logic [OPF_W-1:0] OP_CMP_S  = 9'h051;
    localparam logic [OPF_W-1:0] OP_CMP_D  = 9'h052;
    localparam logic [OPF_W-1:0] OP_CMP_Q  = 9'h053;
    localparam logic [OPF_W-1:0] OP_CMPX_S = 9'h055;
    localparam logic [OPF_W-1:0] OP_CMPX_D = 9'h056;
    localparam logic [OPF_W-1:0] OP_CMPX_Q = 9'h057;

    function automatic opsig_t mk_sig(opsz_e a, opsz_e b, opsz_e d);
        opsig_t s;
        s.a = a;
        s.b = b;
        s.d = d;
        return s;
    endfunction

endpackage

// File: rtl/fpdec_class.sv
// Module: fpdec_class
// Sorts an instruction word into the general operate group, the compare
// group, or neither. Purely combinational; assumes the fixed group mask.
module fpdec_class
    import fpdec_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output logic              is_arith,
    output logic              is_cmp
);

    logic [INSN_W-1:0] masked;

    // Compare the masked word against the two group patterns
    always_comb begin
        masked   = insn & GRP_MASK;
        is_arith = (masked == GRP_ARITH);
        is_cmp   = (masked == GRP_CMP);
    end

endmodule

// File: rtl/fpdec_optab.sv
// Module: fpdec_optab
// Maps the operation code of a classified word to operand sizes for rs1,
// rs2 and rd. Assumes at most one of is_arith/is_cmp is set. Reports
// known=0 for codes undefined in the selected group.
module fpdec_optab
    import fpdec_pkg::*;
(
    input  logic             is_arith,
    input  logic             is_cmp,
    input  logic [OPF_W-1:0] opf,
    output logic             known,
    output opsig_t           sig
);

    opsig_t arith_sig;
    opsig_t cmp_sig;
    logic   arith_hit;
    logic   cmp_hit;

    // General group lookup
    always_comb begin
        arith_hit = 1'b1;
        arith_sig = SIG_NONE;
        case (opf)
            OP_MOV_S, OP_NEG_S, OP_ABS_S:
                arith_sig = mk_sig(SZ_NONE, SZ_WORD, SZ_WORD);
            OP_SQR_S: arith_sig = mk_sig(SZ_NONE, SZ_SGL,  SZ_SGL);
            OP_SQR_D: arith_sig = mk_sig(SZ_NONE, SZ_DBL,  SZ_DBL);
            OP_SQR_Q: arith_sig = mk_sig(SZ_NONE, SZ_QUAD, SZ_QUAD);
            OP_ADD_S, OP_SUB_S, OP_MUL_S, OP_DIV_S:
                arith_sig = mk_sig(SZ_SGL, SZ_SGL, SZ_SGL);
            OP_ADD_D, OP_SUB_D, OP_MUL_D, OP_DIV_D:
                arith_sig = mk_sig(SZ_DBL, SZ_DBL, SZ_DBL);
            OP_ADD_Q, OP_SUB_Q, OP_MUL_Q, OP_DIV_Q:
                arith_sig = mk_sig(SZ_QUAD, SZ_QUAD, SZ_QUAD);
            OP_WMUL_D: arith_sig = mk_sig(SZ_SGL, SZ_SGL, SZ_DBL);
            OP_WMUL_Q: arith_sig = mk_sig(SZ_DBL, SZ_DBL, SZ_QUAD);
            OP_I2S:    arith_sig = mk_sig(SZ_NONE, SZ_WORD, SZ_SGL);
            OP_I2D:    arith_sig = mk_sig(SZ_NONE, SZ_WORD, SZ_DBL);
            OP_I2Q:    arith_sig = mk_sig(SZ_NONE, SZ_WORD, SZ_QUAD);
            OP_S2D:    arith_sig = mk_sig(SZ_NONE, SZ_SGL,  SZ_DBL);
            OP_S2Q:    arith_sig = mk_sig(SZ_NONE, SZ_SGL,  SZ_QUAD);
            OP_D2S:    arith_sig = mk_sig(SZ_NONE, SZ_DBL,  SZ_SGL);
            OP_D2Q:    arith_sig = mk_sig(SZ_NONE, SZ_DBL,  SZ_QUAD);
            OP_Q2S:    arith_sig = mk_sig(SZ_NONE, SZ_QUAD, SZ_SGL);
            OP_Q2D:    arith_sig = mk_sig(SZ_NONE, SZ_QUAD, SZ_DBL);
            OP_S2I:    arith_sig = mk_sig(SZ_NONE, SZ_SGL,  SZ_WORD);
            OP_D2I:    arith_sig = mk_sig(SZ_NONE, SZ_DBL,  SZ_WORD);
            OP_Q2I:    arith_sig = mk_sig(SZ_NONE, SZ_QUAD, SZ_WORD);
            default:   arith_hit = 1'b0;
        endcase
    end

    // Compare group lookup
    always_comb begin
        cmp_hit = 1'b1;
        cmp_sig = SIG_NONE;
        case (opf)
            OP_CMP_S, OP_CMPX_S: cmp_sig = mk_sig(SZ_SGL,  SZ_SGL,  SZ_FCC);
            OP_CMP_D, OP_CMPX_D: cmp_sig = mk_sig(SZ_DBL,  SZ_DBL,  SZ_FCC);
            OP_CMP_Q, OP_CMPX_Q: cmp_sig = mk_sig(SZ_QUAD, SZ_QUAD, SZ_FCC);
            default:             cmp_hit = 1'b0;
        endcase
    end

    // Select by group; unknown codes yield no sizes
    always_comb begin
        known = 1'b0;
        sig   = SIG_NONE;
        if (is_arith && arith_hit) begin
            known = 1'b1;
            sig   = arith_sig;
        end else if (is_cmp && cmp_hit) begin
            known = 1'b1;
            sig   = cmp_sig;
        end
    end

endmodule

// File: rtl/fpdec_regchk.sv
// Module: fpdec_regchk
// Checks one register number against its operand size: doubles need an
// even number, quads a multiple of four, a condition-code destination
// must be zero. Other sizes always pass.
module fpdec_regchk
    import fpdec_pkg::*;
(
    input  opsz_e            size,
    input  logic [REG_W-1:0] idx,
    output logic             bad
);

    // Alignment rule per size
    always_comb begin
        case (size)
            SZ_DBL:  bad = idx[0];
            SZ_QUAD: bad = |idx[1:0];
            SZ_FCC:  bad = |idx;
            default: bad = 1'b0;
        endcase
    end

endmodule

// File: rtl/fpdec_errsel.sv
// Module: fpdec_errsel
// Picks the first failing operand in check order (rs1, rs2, rd) and
// encodes it as 1, 2 or 3; 0 when none failed.
module fpdec_errsel
    import fpdec_pkg::*;
(
    input  logic [NUM_OPERANDS-1:0] bad,
    output logic                    any_bad,
    output logic [SRC_W-1:0]        src
);

    // Lowest index wins
    always_comb begin
        src = '0;
        for (int i = NUM_OPERANDS - 1; i >= 0; i--) begin
            if (bad[i]) src = SRC_W'(i + 1);
        end
        any_bad = |bad;
    end

endmodule

// File: rtl/fpop_decoder.sv
// Module: fpop_decoder
// Top of the floating-point operate decoder. Classifies the word, looks up
// operand sizes, checks register alignment and registers the result one
// cycle after in_valid. Outputs hold between strobes. Synchronous
// active-low reset clears everything.
module fpop_decoder
    import fpdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       insn,
    output logic              dec_valid,
    output logic              dec_ok,
    output logic              dec_unimp,
    output logic              dec_reg_err,
    output logic [2:0]        dec_trap_type,
    output logic [1:0]        dec_err_src,
    output logic [8:0]        dec_opf,
    output logic [2:0]        dec_rs1_sz,
    output logic [2:0]        dec_rs2_sz,
    output logic [2:0]        dec_rd_sz,
    output logic [4:0]        dec_rs1,
    output logic [4:0]        dec_rs2,
    output logic [4:0]        dec_rd
);

    logic                    is_arith;
    logic                    is_cmp;
    logic                    known;
    opsig_t                  sig;
    logic [OPF_W-1:0]        opf;
    logic [REG_W-1:0]        idx   [NUM_OPERANDS];
    opsz_e                   sizes [NUM_OPERANDS];
    logic [NUM_OPERANDS-1:0] bad;
    logic                    any_bad;
    logic [SRC_W-1:0]        src;

    // Field extraction
    always_comb begin
        opf    = insn[OPF_LO +: OPF_W];
        idx[0] = insn[RS1_LO +: REG_W];
        idx[1] = insn[RS2_LO +: REG_W];
        idx[2] = insn[RD_LO  +: REG_W];
    end

    // Size fan-out into operand order
    always_comb begin
        sizes[0] = sig.a;
        sizes[1] = sig.b;
        sizes[2] = sig.d;
    end

    fpdec_class u_class (
        .insn     (insn),
        .is_arith (is_arith),
        .is_cmp   (is_cmp)
    );

    fpdec_optab u_optab (
        .is_arith (is_arith),
        .is_cmp   (is_cmp),
        .opf      (opf),
        .known    (known),
        .sig      (sig)
    );

    for (genvar g = 0; g < NUM_OPERANDS; g++) begin : g_chk
        fpdec_regchk u_chk (
            .size (sizes[g]),
            .idx  (idx[g]),
            .bad  (bad[g])
        );
    end

    fpdec_errsel u_errsel (
        .bad     (bad),
        .any_bad (any_bad),
        .src     (src)
    );

    // Output register: capture on strobe, pulse dec_valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid     <= 1'b0;
            dec_ok        <= 1'b0;
            dec_unimp     <= 1'b0;
            dec_reg_err   <= 1'b0;
            dec_trap_type <= TT_NONE;
            dec_err_src   <= '0;
            dec_opf       <= '0;
            dec_rs1_sz    <= '0;
            dec_rs2_sz    <= '0;
            dec_rd_sz     <= '0;
            dec_rs1       <= '0;
            dec_rs2       <= '0;
            dec_rd        <= '0;
        end else begin
            dec_valid <= in_valid;
            if (in_valid) begin
                dec_ok        <= known && !any_bad;
                dec_unimp     <= !known;
                dec_reg_err   <= known && any_bad;
                dec_trap_type <= (known && any_bad) ? TT_BADREG : TT_NONE;
                dec_err_src   <= known ? src : '0;
                dec_opf       <= opf;
                dec_rs1_sz    <= sig.a;
                dec_rs2_sz    <= sig.b;
                dec_rd_sz     <= sig.d;
                dec_rs1       <= idx[0];
                dec_rs2       <= idx[1];
                dec_rd        <= idx[2];
            end
        end
    end

endmodule

// File: rtl/fpop_decoder_chk.sv
// Module: fpop_decoder_chk
// Assertion checker for fpop_decoder, attached by bind. Observes ports only.
module fpop_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] insn,
    input logic        dec_valid,
    input logic        dec_ok,
    input logic        dec_unimp,
    input logic        dec_reg_err,
    input logic [2:0]  dec_trap_type,
    input logic [1:0]  dec_err_src,
    input logic [8:0]  dec_opf,
    input logic [2:0]  dec_rs1_sz,
    input logic [2:0]  dec_rs2_sz,
    input logic [2:0]  dec_rd_sz,
    input logic [4:0]  dec_rs1,
    input logic [4:0]  dec_rs2,
    input logic [4:0]  dec_rd
);

    p_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> dec_valid);

    p_no_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!dec_valid && $stable(dec_opf) && $stable(dec_rd)
                       && $stable(dec_rs1_sz) && $stable(dec_err_src)));

    p_unimp_sizes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_unimp) |->
            (dec_rs1_sz == 3'd0 && dec_rs2_sz == 3'd0 && dec_rd_sz == 3'd0
             && dec_err_src == 2'd0));

    p_dbl_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_reg_err && dec_rs1_sz == 3'd2) |-> !dec_rs1[0]);

    p_quad_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_reg_err && dec_rs2_sz == 3'd3) |-> (dec_rs2[1:0] == 2'b00));

    p_cmp_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_reg_err && dec_rd_sz == 3'd5) |-> (dec_rd == 5'd0));

    p_trap_type_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> ((dec_trap_type == 3'd6) == dec_reg_err)
                      && (dec_trap_type == 3'd6 || dec_trap_type == 3'd0));

    p_err_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> ((dec_err_src != 2'd0) == dec_reg_err));

    p_one_outcome_r12: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> ($countones({dec_ok, dec_unimp, dec_reg_err}) == 1));

endmodule

bind fpop_decoder fpop_decoder_chk u_fpop_decoder_chk (.*);

// File: tb/fpop_decoder_test.sv
`timescale 1ns/1ps
module fpop_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] insn = '0;
    logic        dec_valid, dec_ok, dec_unimp, dec_reg_err;
    logic [2:0]  dec_trap_type;
    logic [1:0]  dec_err_src;
    logic [8:0]  dec_opf;
    logic [2:0]  dec_rs1_sz, dec_rs2_sz, dec_rd_sz;
    logic [4:0]  dec_rs1, dec_rs2, dec_rd;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fpop_decoder uut (.*);

    // Expected results
    int e_s1, e_s2, e_sd, e_src;
    bit e_known, e_ok, e_unimp, e_err;

    function automatic bit lookup(input bit g_ar, input bit g_cm, input int op,
                                  output int s1, output int s2, output int sd);
        s1 = 0; s2 = 0; sd = 0;
        if (g_cm) begin
            if (op == 'h51 || op == 'h55) begin s1 = 1; s2 = 1; sd = 5; return 1; end
            if (op == 'h52 || op == 'h56) begin s1 = 2; s2 = 2; sd = 5; return 1; end
            if (op == 'h53 || op == 'h57) begin s1 = 3; s2 = 3; sd = 5; return 1; end
            return 0;
        end
        if (!g_ar) return 0;
        if (op == 'h01 || op == 'h05 || op == 'h09) begin s2 = 4; sd = 4; return 1; end
        if (op >= 'h29 && op <= 'h2B) begin s2 = op - 'h28; sd = s2; return 1; end
        if (op >= 'h41 && op <= 'h4F && (op & 3) != 0) begin
            s1 = op & 3; s2 = s1; sd = s1; return 1;
        end
        if (op == 'h69) begin s1 = 1; s2 = 1; sd = 2; return 1; end
        if (op == 'h6E) begin s1 = 2; s2 = 2; sd = 3; return 1; end
        if (op == 'hC4) begin s2 = 4; sd = 1; return 1; end
        if (op == 'hC8) begin s2 = 4; sd = 2; return 1; end
        if (op == 'hCC) begin s2 = 4; sd = 3; return 1; end
        if (op == 'hC9) begin s2 = 1; sd = 2; return 1; end
        if (op == 'hCD) begin s2 = 1; sd = 3; return 1; end
        if (op == 'hCE) begin s2 = 2; sd = 3; return 1; end
        if (op == 'hC6) begin s2 = 2; sd = 1; return 1; end
        if (op == 'hC7) begin s2 = 3; sd = 1; return 1; end
        if (op == 'hCB) begin s2 = 3; sd = 2; return 1; end
        if (op >= 'hD1 && op <= 'hD3) begin s2 = op - 'hD0; sd = 4; return 1; end
        return 0;
    endfunction

    function automatic bit misaligned(input int sz, input logic [4:0] r);
        if (sz == 2) return r[0];
        if (sz == 3) return r[1:0] != 2'b00;
        if (sz == 5) return r != 5'd0;
        return 0;
    endfunction

    task automatic predict(input logic [31:0] w);
        bit g_ar, g_cm;
        g_ar = (w & 32'hC1F80000) == 32'h81A00000;
        g_cm = (w & 32'hC1F80000) == 32'h81A80000;
        e_known = lookup(g_ar, g_cm, int'(w[13:5]), e_s1, e_s2, e_sd);
        e_src = 0;
        if (e_known) begin
            if (misaligned(e_s1, w[18:14]))      e_src = 1;
            else if (misaligned(e_s2, w[4:0]))   e_src = 2;
            else if (misaligned(e_sd, w[29:25])) e_src = 3;
        end
        e_err   = e_known && e_src != 0;
        e_ok    = e_known && e_src == 0;
        e_unimp = !e_known;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d insn=%08h", tag, act, exp, insn);
        end
    endtask

    task automatic check_outputs(input logic [31:0] w, input bit strobe);
        chk("R2 dec_valid", dec_valid, strobe);
        chk("R4 dec_opf", dec_opf, w[13:5]);
        chk("R4 dec_rs1", dec_rs1, w[18:14]);
        chk("R4 dec_rs2", dec_rs2, w[4:0]);
        chk("R4 dec_rd", dec_rd, w[29:25]);
        chk("R5 dec_rs1_sz", dec_rs1_sz, e_s1);
        chk("R5 dec_rs2_sz", dec_rs2_sz, e_s2);
        chk("R5 dec_rd_sz", dec_rd_sz, e_sd);
        chk("R3/R6 dec_unimp", dec_unimp, e_unimp);
        chk("R12 dec_ok", dec_ok, e_ok);
        chk("R7/R8/R9/R13 dec_reg_err", dec_reg_err, e_err);
        chk("R10 dec_trap_type", dec_trap_type, e_err ? 6 : 0);
        chk("R11 dec_err_src", dec_err_src, e_src);
    endtask

    // Strobe one word, check the registered result, then check it holds
    task automatic send(input logic [31:0] w);
        logic [31:0] other;
        @(negedge clk);
        insn = w; in_valid = 1'b1;
        predict(w);
        @(negedge clk);
        in_valid = 1'b0;
        other = ~w;
        insn = other;
        check_outputs(w, 1'b1);
        @(negedge clk);
        check_outputs(w, 1'b0); // R2 hold without strobe
    endtask

    function automatic logic [31:0] mk(input bit cmp, input logic [8:0] op,
                                       input logic [4:0] a, input logic [4:0] b,
                                       input logic [4:0] d);
        return {2'b10, d, 5'b11010, cmp, a, op, b};
    endfunction

    logic [8:0] known_ops [0:37];

    initial begin
        int k;
        k = 0;
        foreach (known_ops[i]) known_ops[i] = 9'h041;
        known_ops[k++] = 9'h001; known_ops[k++] = 9'h005; known_ops[k++] = 9'h009;
        for (int j = 'h29; j <= 'h2B; j++) known_ops[k++] = 9'(j);
        for (int j = 'h41; j <= 'h4F; j++) if ((j & 3) != 0) known_ops[k++] = 9'(j);
        known_ops[k++] = 9'h069; known_ops[k++] = 9'h06E;
        known_ops[k++] = 9'h0C4; known_ops[k++] = 9'h0C6; known_ops[k++] = 9'h0C7;
        known_ops[k++] = 9'h0C8; known_ops[k++] = 9'h0C9; known_ops[k++] = 9'h0CB;
        known_ops[k++] = 9'h0CC; known_ops[k++] = 9'h0CD; known_ops[k++] = 9'h0CE;
        known_ops[k++] = 9'h0D1; known_ops[k++] = 9'h0D2; known_ops[k++] = 9'h0D3;
        known_ops[k++] = 9'h051; known_ops[k++] = 9'h052; known_ops[k++] = 9'h053;
        known_ops[k++] = 9'h055; known_ops[k++] = 9'h056;
        known_ops[k++] = 9'h057;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: outputs zero during reset
        e_s1 = 0; e_s2 = 0; e_sd = 0; e_src = 0; e_ok = 0; e_unimp = 0; e_err = 0;
        check_outputs(32'h0, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check_outputs(32'h0, 1'b0); // R1 after release

        send(mk(0, 9'h042, 5'd4, 5'd6, 5'd8));    // R5 double add legal
        send(mk(0, 9'h042, 5'd5, 5'd6, 5'd8));    // R7 rs1 odd -> src 1
        send(mk(0, 9'h043, 5'd4, 5'd2, 5'd8));    // R8 rs2 not multiple of 4 -> src 2
        send(mk(1, 9'h051, 5'd3, 5'd7, 5'd1));    // R9 compare rd nonzero -> src 3
        send(mk(1, 9'h057, 5'd1, 5'd2, 5'd3));    // R11 all bad -> src 1
        send(mk(1, 9'h056, 5'd2, 5'd3, 5'd4));    // R11 rs2 and rd bad -> src 2
        send(mk(0, 9'h001, 5'd31, 5'd31, 5'd31)); // R13 move, any regs legal
        send(mk(0, 9'h0C8, 5'd9, 5'd7, 5'd3));    // R13 raw source ok, rd odd -> src 3
        send(mk(0, 9'h069, 5'd1, 5'd3, 5'd2));    // R5 widening multiply
        send(mk(0, 9'h051, 5'd0, 5'd0, 5'd0));    // R6 compare code in general group
        send(mk(1, 9'h041, 5'd0, 5'd0, 5'd0));    // R6 general code in compare group
        send(mk(0, 9'h1FF, 5'd0, 5'd0, 5'd0));    // R6 undefined code
        send(32'h0000_0000);                      // R3 not an operate word
        send(mk(0, 9'h042, 5'd4, 5'd6, 5'd8) ^ 32'h4000_0000); // R3 bit 30 breaks group

        // Back-to-back strobes (R2)
        @(negedge clk);
        insn = mk(0, 9'h04A, 5'd2, 5'd4, 5'd6); in_valid = 1'b1;
        @(negedge clk);
        insn = mk(1, 9'h053, 5'd4, 5'd8, 5'd0);
        predict(mk(0, 9'h04A, 5'd2, 5'd4, 5'd6));
        check_outputs(mk(0, 9'h04A, 5'd2, 5'd4, 5'd6), 1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        predict(mk(1, 9'h053, 5'd4, 5'd8, 5'd0));
        check_outputs(mk(1, 9'h053, 5'd4, 5'd8, 5'd0), 1'b1);

        // Constrained random mix
        for (int n = 0; n < 600; n++) begin
            logic [31:0] w;
            int sel;
            sel = $urandom_range(0, 9);
            if (sel == 0) w = $urandom;
            else if (sel == 1) w = mk(1'($urandom), 9'($urandom), 5'($urandom), 5'($urandom), 5'($urandom));
            else begin
                logic [8:0] op;
                op = known_ops[$urandom_range(0, 37)];
                w = mk(op[8:4] == 5'h05, op, 5'($urandom), 5'($urandom),
                       ($urandom_range(0, 1) != 0) ? 5'd0 : 5'($urandom));
            end
            send(w);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule